// File: doc/BRIEF.md
# Byte-Serial AES-128 Encrypt/Decrypt Core

This block ciphers one 128-bit block under one 128-bit key per run, in either direction. The direction comes from a `decrypt` input that is sampled together with `start`. Block and key bytes enter over two byte-wide inputs, sixteen cycles in a row. Both the cipher state and the round key live in byte-wide shift-register arrays. Substitution, key addition and round-key derivation go through the logic one byte per cycle. Rows are rotated inside the array over three cycles using per-row enables. A single column mixer that only computes the forward transform covers decryption as well: it is applied three times per column, because the inverse matrix is the cube of the forward one.

For decryption, the key array is first run forward to the last round key. The schedule is then walked backwards one round key per round, while the round constant is divided by x. Once the result is ready, the core pulses `done` and streams the sixteen result bytes out, first byte first. While it is working it ignores any new `start`.

Top module: `aes_serial_core`

## Requirements
- R1: While reset is held and straight after it, `busy`, `done` and `outValid` are 0 and `dataOut` is 0x00.
- R2: With `decrypt`=0 at start, the streamed result equals AES-128 encryption of the loaded block under the loaded key. Byte i of the stream (i = 0 first) is byte i of the block, in the standard column-major state order; input bytes use the same order.
- R3: With `decrypt`=1 at start, the streamed result equals AES-128 decryption of the loaded block under the loaded key. The key given is the cipher key, not the last round key.
- R4: Decrypting the output of an encryption under the same key returns the original block.
- R5: In encryption, `done` goes high exactly 242 clock cycles after the edge that takes the sixteenth input byte.
- R6: In decryption, `done` goes high exactly 474 clock cycles after the edge that takes the sixteenth input byte.
- R7: `done` is high for exactly one cycle per run, and that is the first of exactly 16 consecutive `outValid` cycles that carry the result bytes.
- R8: A `start` pulse, or new `dataIn`/`keyIn` values, presented while `busy` is high change neither the result nor its timing.
- R9: `busy` rises on the edge that takes `start` and falls after the last output byte. The core then accepts a new `start`.
- R10: The direction is latched at start. Toggling `decrypt` while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; byte 0 is taken in the same cycle |
| decrypt | input | 1 | Direction for the run: 1 = decrypt, 0 = encrypt |
| dataIn | input | 8 | Block byte, one per cycle for 16 cycles from start |
| keyIn | input | 8 | Key byte, one per cycle for 16 cycles from start |
| busy | output | 1 | High from start until the last result byte |
| done | output | 1 | One-cycle pulse with the first result byte |
| outValid | output | 1 | High while `dataOut` carries a result byte |
| dataOut | output | 8 | Result byte stream, byte 0 first |

## Verification
The bench runs known-answer vectors both ways. This exercises the reverse key recurrence, the division of the round constant past its wrap value 0x1b, and the triple pass of the column mixer. A reverse schedule that is off by one round key, or a mixer run once instead of three times in decryption, gives a wrong block even though the encryption results are still right. Exact latency counts catch a round with a missing or extra mixing or shifting step. A final round that mixes columns fails the known-answer vectors. Start pulses, direction toggles and stray input bytes during a run check that the core cannot be restarted or redirected midway; a core that took them would return a different block or change its timing.

// File: rtl/aes_serial_pkg.sv
package aes_serial_pkg;

  localparam int NB     = 16;   // bytes per block and per key
  localparam int ROWS   = 4;
  localparam int COLS   = NB / ROWS;
  localparam int ROUNDS = 10;
  localparam int CNT_W  = $clog2(NB);
  localparam int RND_W  = $clog2(ROUNDS + 1);
  localparam int SHIFT_CYC = ROWS - 1;
  localparam int MIX_REP_DEC = 3;
  localparam int ENC_CYC = ROUNDS * (NB + SHIFT_CYC) + (ROUNDS - 1) * COLS + NB;
  localparam int DEC_CYC = ROUNDS * NB + NB + ROUNDS * (SHIFT_CYC + NB)
                         + (ROUNDS - 1) * MIX_REP_DEC * COLS;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_KEYADV, ST_XOR, ST_SHIFT, ST_SUB, ST_MIX, ST_OUT
  } phase_t;

  typedef struct packed {
    logic             load;      // take a byte from dataIn/keyIn
    logic             pass;      // byte-serial pass over the state
    logic             useSbox;   // pass goes through substitution
    logic             keyShift;  // rotate the key array one byte
    logic             keyUpd;    // rotate with the next/previous round key byte
    logic             keyRev;    // schedule runs backwards
    logic [ROWS-1:0]  rowEn;     // rows that rotate this cycle
    logic             mix;       // column mixer on the head column
    logic             unload;    // shift one result byte out
    logic [CNT_W-1:0] byteIdx;   // position inside the current pass
    logic             dec;       // latched direction
  } ctrl_t;

  function automatic logic [7:0] gfXtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfDivX(input logic [7:0] a);
    return a[0] ? ({1'b0, a[7:1]} ^ 8'h8d) : {1'b0, a[7:1]};
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfXtime(sh);
    end
    return acc;
  endfunction

  // a^254: zero maps to zero
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    res = 8'h01;
    pw  = a;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      res = gfMul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_serial_pkg::*;
(
  input  logic [7:0] din,
  input  logic       inv,
  output logic [7:0] dout
);
  logic [7:0] preAff;
  logic [7:0] invVal;
  logic [7:0] postAff;

  always_comb begin
    preAff  = inv ? (rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ 8'h05) : din;
    invVal  = gfInv(preAff);
    postAff = invVal ^ rotl8(invVal, 1) ^ rotl8(invVal, 2)
            ^ rotl8(invVal, 3) ^ rotl8(invVal, 4) ^ 8'h63;
    dout    = inv ? invVal : postAff;
  end
endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol
  import aes_serial_pkg::*;
(
  input  logic [ROWS-1:0][7:0] colIn,
  output logic [ROWS-1:0][7:0] colOut
);
  logic [ROWS-1:0][7:0] dbl;

  always_comb begin
    for (int r = 0; r < ROWS; r++) dbl[r] = gfXtime(colIn[r]);
    colOut[0] = dbl[0] ^ dbl[1] ^ colIn[1] ^ colIn[2] ^ colIn[3];
    colOut[1] = colIn[0] ^ dbl[1] ^ dbl[2] ^ colIn[2] ^ colIn[3];
    colOut[2] = colIn[0] ^ colIn[1] ^ dbl[2] ^ dbl[3] ^ colIn[3];
    colOut[3] = dbl[0] ^ colIn[0] ^ colIn[1] ^ colIn[2] ^ dbl[3];
  end
endmodule

// File: rtl/aes_datapath.sv
module aes_datapath
  import aes_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_t      ctl,
  input  logic [7:0] dataIn,
  input  logic [7:0] keyIn,
  output logic [7:0] dataOut
);
  localparam int DL = ROWS;   // delay of old key bytes for the reverse schedule

  logic [7:0] st     [NB];
  logic [7:0] stNext [NB];
  logic [7:0] ky     [NB];
  logic [7:0] dly    [DL];
  logic [7:0] rcReg;

  logic [7:0] keyedByte, sboxIn, sboxOut, passOut;
  logic [7:0] ksIn, ksOut, rcUse, kNew;
  logic       headWord, lastOfWord;
  logic [ROWS-1:0][7:0] mixIn, mixOut;

  // shared data substitution: forward or inverse chosen by direction
  assign keyedByte = st[0] ^ ky[0];
  assign sboxIn    = ctl.dec ? st[0] : keyedByte;

  aes_sbox u_dataSbox (.din(sboxIn), .inv(ctl.dec), .dout(sboxOut));

  always_comb begin
    if (!ctl.useSbox)  passOut = keyedByte;
    else if (ctl.dec)  passOut = sboxOut ^ ky[0];
    else               passOut = sboxOut;
  end

  // byte-serial round-key derivation
  assign headWord   = (ctl.byteIdx[CNT_W-1:2] == '0);
  assign lastOfWord = (ctl.byteIdx == CNT_W'(ROWS - 1));

  always_comb begin
    if (ctl.keyRev) ksIn = lastOfWord ? (ky[9] ^ ky[5]) : (ky[13] ^ ky[9]);
    else            ksIn = lastOfWord ? ky[9] : ky[13];
  end

  aes_sbox u_keySbox (.din(ksIn), .inv(1'b0), .dout(ksOut));

  assign rcUse = ctl.keyRev ? gfDivX(rcReg) : rcReg;

  always_comb begin
    if (headWord)
      kNew = ky[0] ^ ksOut ^ ((ctl.byteIdx == '0) ? rcUse : 8'h00);
    else
      kNew = ky[0] ^ (ctl.keyRev ? dly[DL-1] : ky[NB-ROWS]);
  end

  // column mixer on the head column
  always_comb begin
    for (int r = 0; r < ROWS; r++) mixIn[r] = st[r];
  end

  aes_mixcol u_mix (.colIn(mixIn), .colOut(mixOut));

  // next state of the data array
  always_comb begin
    for (int j = 0; j < NB; j++) stNext[j] = st[j];
    if (ctl.load || ctl.pass || ctl.unload) begin
      for (int j = 0; j < NB - 1; j++) stNext[j] = st[j+1];
      if (ctl.load)      stNext[NB-1] = dataIn;
      else if (ctl.pass) stNext[NB-1] = passOut;
      else               stNext[NB-1] = 8'h00;
    end else if (ctl.mix) begin
      for (int j = 0; j < NB - ROWS; j++) stNext[j] = st[j+ROWS];
      for (int r = 0; r < ROWS; r++) stNext[NB-ROWS+r] = mixOut[r];
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (ctl.rowEn[r]) begin
          for (int c = 0; c < COLS; c++) begin
            if (ctl.dec) stNext[c*ROWS+r] = st[((c+COLS-1)%COLS)*ROWS+r];
            else         stNext[c*ROWS+r] = st[((c+1)%COLS)*ROWS+r];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < NB; j++) st[j] <= 8'h00;
    end else begin
      for (int j = 0; j < NB; j++) st[j] <= stNext[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < NB; j++) ky[j] <= 8'h00;
      for (int j = 0; j < DL; j++) dly[j] <= 8'h00;
      rcReg <= 8'h01;
    end else if (ctl.load) begin
      for (int j = 0; j < NB - 1; j++) ky[j] <= ky[j+1];
      ky[NB-1] <= keyIn;
      rcReg    <= 8'h01;
    end else if (ctl.keyShift) begin
      for (int j = 0; j < NB - 1; j++) ky[j] <= ky[j+1];
      ky[NB-1] <= ctl.keyUpd ? kNew : ky[0];
      dly[0]   <= ky[0];
      for (int j = 1; j < DL; j++) dly[j] <= dly[j-1];
      if (ctl.keyUpd && ctl.byteIdx == '0)
        rcReg <= ctl.keyRev ? rcUse : gfXtime(rcReg);
    end
  end

  assign dataOut = st[0];
endmodule

// File: rtl/aes_control.sv
module aes_control
  import aes_serial_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  decrypt,
  output ctrl_t ctl,
  output logic  busy,
  output logic  done,
  output logic  outValid
);
  localparam logic [CNT_W-1:0] PASS_LAST  = CNT_W'(NB - 1);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(NB - 2);
  localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(SHIFT_CYC - 1);
  localparam logic [CNT_W-1:0] MIX_ENC    = CNT_W'(COLS - 1);
  localparam logic [CNT_W-1:0] MIX_DEC    = CNT_W'(MIX_REP_DEC * COLS - 1);
  localparam logic [RND_W-1:0] RND_LAST   = RND_W'(ROUNDS - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [RND_W-1:0] rnd;
  logic             decReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      rnd    <= '0;
      decReg <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (phase)
        ST_IDLE: begin
          cnt <= '0;
          if (start) begin
            decReg <= decrypt;
            phase  <= ST_LOAD;
          end
        end
        ST_LOAD: if (cnt == LOAD_LAST) begin
          cnt   <= '0;
          rnd   <= '0;
          phase <= decReg ? ST_KEYADV : ST_SUB;
        end
        ST_KEYADV: if (cnt == PASS_LAST) begin
          cnt <= '0;
          if (rnd == RND_LAST) begin
            rnd   <= '0;
            phase <= ST_XOR;
          end else begin
            rnd <= rnd + 1'b1;
          end
        end
        ST_XOR: if (cnt == PASS_LAST) begin
          cnt   <= '0;
          phase <= decReg ? ST_SHIFT : ST_OUT;
        end
        ST_SHIFT: if (cnt == SHIFT_LAST) begin
          cnt <= '0;
          if (decReg)                phase <= ST_SUB;
          else if (rnd == RND_LAST)  phase <= ST_XOR;
          else                       phase <= ST_MIX;
        end
        ST_SUB: if (cnt == PASS_LAST) begin
          cnt <= '0;
          if (!decReg)               phase <= ST_SHIFT;
          else if (rnd == RND_LAST)  phase <= ST_OUT;
          else                       phase <= ST_MIX;
        end
        ST_MIX: if (cnt == (decReg ? MIX_DEC : MIX_ENC)) begin
          cnt   <= '0;
          rnd   <= rnd + 1'b1;
          phase <= decReg ? ST_SHIFT : ST_SUB;
        end
        ST_OUT: if (cnt == PASS_LAST) begin
          cnt   <= '0;
          phase <= ST_IDLE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.byteIdx = cnt;
    ctl.dec     = decReg;
    unique case (phase)
      ST_IDLE:   ctl.load = start;
      ST_LOAD:   ctl.load = 1'b1;
      ST_KEYADV: begin
        ctl.keyShift = 1'b1;
        ctl.keyUpd   = 1'b1;
      end
      ST_XOR: begin
        ctl.pass     = 1'b1;
        ctl.keyShift = 1'b1;
        ctl.keyUpd   = decReg;
        ctl.keyRev   = 1'b1;
      end
      ST_SUB: begin
        ctl.pass     = 1'b1;
        ctl.useSbox  = 1'b1;
        ctl.keyShift = 1'b1;
        ctl.keyUpd   = !decReg || (rnd != RND_LAST);
        ctl.keyRev   = decReg;
      end
      ST_SHIFT: begin
        for (int r = 0; r < ROWS; r++) ctl.rowEn[r] = (CNT_W'(r) > cnt);
      end
      ST_MIX:    ctl.mix    = 1'b1;
      ST_OUT:    ctl.unload = 1'b1;
      default:   ctl.load   = 1'b0;
    endcase
  end

  assign busy     = (phase != ST_IDLE);
  assign outValid = (phase == ST_OUT);
  assign done     = (phase == ST_OUT) && (cnt == '0);
endmodule

// File: rtl/aes_serial_core.sv
module aes_serial_core
  import aes_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       decrypt,
  input  logic [7:0] dataIn,
  input  logic [7:0] keyIn,
  output logic       busy,
  output logic       done,
  output logic       outValid,
  output logic [7:0] dataOut
);
  ctrl_t ctl;

  aes_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .ctl(ctl), .busy(busy), .done(done), .outValid(outValid)
  );

  aes_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dataIn(dataIn), .keyIn(keyIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/aes_serial_chk.sv
module aes_serial_chk
  import aes_serial_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic start,
  input logic decrypt,
  input logic busy,
  input logic done,
  input logic outValid
);
  logic [9:0] busyCyc;
  logic       decSeen;
  logic [9:0] expCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCyc <= '0;
      decSeen <= 1'b0;
    end else begin
      if (!busy && start) decSeen <= decrypt;
      if (!busy)                busyCyc <= '0;
      else if (!outValid)       busyCyc <= busyCyc + 1'b1;
    end
  end

  assign expCyc = decSeen ? 10'(NB - 1 + DEC_CYC) : 10'(NB - 1 + ENC_CYC);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!done && !outValid));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !decSeen) |-> (busyCyc == expCyc));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && decSeen) |-> (busyCyc == expCyc));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && outValid));

  assert_done_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(outValid)) |-> done);

  assert_start_takes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !outValid) |=> busy);
endmodule

bind aes_serial_core aes_serial_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
  .busy(busy), .done(done), .outValid(outValid)
);

// File: tb/sim_aes_serial_core.sv
`timescale 1ns/1ps
module sim_aes_serial_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       decrypt = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] keyIn = 8'h00;
  logic       busy, done, outValid;
  logic [7:0] dataOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // {key, plaintext, ciphertext}
  localparam logic [383:0] VEC [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f,
     128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h00000000000000000000000000000000,
     128'h00000000000000000000000000000000,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  always #2.5 clk = ~clk;

  aes_serial_core u0 (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .dataIn(dataIn), .keyIn(keyIn), .busy(busy), .done(done),
    .outValid(outValid), .dataOut(dataOut)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runBlock(input logic [127:0] key, input logic [127:0] blk,
                          input logic dec, input bit disturb,
                          output logic [127:0] res, output int lat,
                          output int doneCnt, output int validCnt,
                          output logic idleAfter);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      start   = (i == 0);
      decrypt = dec;
      dataIn  = blk[127-8*i -: 8];
      keyIn   = key[127-8*i -: 8];
      @(posedge clk);
      @(negedge clk);
    end
    start  = 1'b0;
    dataIn = 8'h00;
    keyIn  = 8'h00;
    lat = 0;
    while (!done && lat < 3000) begin
      if (disturb && lat == 40) begin
        start   = 1'b1;
        decrypt = !dec;
        dataIn  = 8'h5a;
        keyIn   = 8'hc3;
      end else if (disturb && lat == 41) begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    decrypt = dec;
    res = '0;
    doneCnt = 0;
    validCnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (outValid) begin
        if (validCnt < 16) res[127-8*validCnt -: 8] = dataOut;
        validCnt++;
      end
      if (done) doneCnt++;
      @(posedge clk);
      @(negedge clk);
    end
    idleAfter = !busy;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [127:0] res;
    logic [127:0] ctMid;
    int lat, dCnt, vCnt;
    logic idle;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && outValid == 1'b0, "R1 flags in reset",
        {125'd0, busy, done, outValid}, 128'd0);
    chk(dataOut == 8'h00, "R1 dataOut in reset", {120'd0, dataOut}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && outValid == 1'b0, "R1 flags after reset",
        {125'd0, busy, done, outValid}, 128'd0);
    chk(dataOut == 8'h00, "R1 dataOut after reset", {120'd0, dataOut}, 128'd0);

    // vector table, both directions
    for (int v = 0; v < 3; v++) begin
      logic [383:0] vec;
      vec = VEC[v];
      runBlock(vec[383:256], vec[255:128], 1'b0, 1'b0, res, lat, dCnt, vCnt, idle);
      chk(res == vec[127:0], "R2 encrypt result", res, vec[127:0]);
      chk(lat == 242, "R5 encrypt latency", 128'(lat), 128'd242);
      chk(dCnt == 1 && vCnt == 16, "R7 done/outValid counts",
          {64'(dCnt), 64'(vCnt)}, {64'd1, 64'd16});
      chk(idle, "R9 busy low after unload", {127'd0, idle}, 128'd1);

      runBlock(vec[383:256], vec[127:0], 1'b1, 1'b0, res, lat, dCnt, vCnt, idle);
      chk(res == vec[255:128], "R3 decrypt result", res, vec[255:128]);
      chk(lat == 474, "R6 decrypt latency", 128'(lat), 128'd474);
      chk(dCnt == 1 && vCnt == 16, "R7 done/outValid counts",
          {64'(dCnt), 64'(vCnt)}, {64'd1, 64'd16});
      chk(idle, "R9 busy low after unload", {127'd0, idle}, 128'd1);
    end

    // R4: round trip on an arbitrary block
    runBlock(128'hfedcba9876543210f0e1d2c3b4a59687,
             128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 1'b0, 1'b0,
             ctMid, lat, dCnt, vCnt, idle);
    chk(ctMid != 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, "R4 cipher differs",
        ctMid, ~ctMid);
    runBlock(128'hfedcba9876543210f0e1d2c3b4a59687, ctMid, 1'b1, 1'b0,
             res, lat, dCnt, vCnt, idle);
    chk(res == 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, "R4 round trip",
        res, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);

    // R8 / R10: start pulse, stray bytes and direction toggle while busy
    runBlock(VEC[0][383:256], VEC[0][255:128], 1'b0, 1'b1, res, lat, dCnt, vCnt, idle);
    chk(res == VEC[0][127:0], "R8 R10 encrypt under disturbance", res, VEC[0][127:0]);
    chk(lat == 242, "R8 encrypt latency under disturbance", 128'(lat), 128'd242);
    runBlock(VEC[1][383:256], VEC[1][127:0], 1'b1, 1'b1, res, lat, dCnt, vCnt, idle);
    chk(res == VEC[1][255:128], "R8 R10 decrypt under disturbance", res, VEC[1][255:128]);
    chk(lat == 474, "R8 decrypt latency under disturbance", 128'(lat), 128'd474);
    chk(dCnt == 1 && vCnt == 16 && idle, "R7 R9 stream after disturbance",
        {63'(dCnt), 64'(vCnt), idle}, {63'd1, 64'd16, 1'b1});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule